// File: doc/BRIEF.md
# Descriptor Ring Index Manager

This block keeps the two circular index pairs that let software and a DMA engine share a transmit ring and a receive ring of descriptors. On the transmit side, software publishes new work by writing the produce index, and the engine steps the consume index each time it finishes sending a frame. On the receive side, the engine steps the produce index each time it stores a frame, and software returns descriptors by writing the consume index. Each ring's size is programmed as the descriptor count minus one, and both indices wrap to zero after that value.

The block reports empty and full conditions for both rings. It keeps one length word per receive slot, holding the stored frame's byte count minus one. It keeps two interrupt status bits, transmit-done and receive-done, each with an enable mask and a write-one-to-clear control. The transmit side is governed by a state machine with the states TX_IDLE (ring empty) and TX_PENDING (work outstanding). The transition TX_IDLE to TX_PENDING happens when the next-cycle indices differ, and TX_PENDING to TX_IDLE happens when they become equal. The receive side has the states RX_RUN and RX_STALL. The transition RX_RUN to RX_STALL happens when the engine offers a frame while the ring is full. The transition RX_STALL to RX_RUN happens once software has freed a slot.

Top module: `ring_index_mgr`

## Requirements
- R1: After reset, all four indices are 0, both rings report empty, neither ring reports full, the interrupt status is 0, `irq_out` is 0 and `rx_overrun` is 0.
- R2: An index advanced by the engine goes from the programmed last value (count minus one) to 0, and otherwise increments by one.
- R3: A ring reports empty exactly when its produce index equals its consume index.
- R4: `tx_full` is 1 when the wrapped successor of `tx_produce` equals `tx_consume`, so at most count minus one transmit descriptors are outstanding.
- R5: A transmit-done pulse from the engine while the transmit ring is empty leaves `tx_consume` unchanged and sets no interrupt.
- R6: An accepted transmit-done with `eng_tx_irq_req` high sets status bit 0 (transmit-done) one cycle later. With the request low, the bit is not set.
- R7: An accepted receive store with `eng_rx_irq_req` high sets status bit 1 (receive-done) one cycle later. With the request low, the bit is not set.
- R8: An accepted receive store writes `eng_rx_len` minus one into the length word of the slot at the current `rx_produce`. That word can be read back through `rx_stat_idx`/`rx_stat_size`.
- R9: A receive store offered while `rx_full` is 1, or while stalled, is dropped. In that case `rx_produce` holds, no interrupt is set, and `rx_overrun` goes to 1. `rx_overrun` stays at 1 until a cycle after software frees a slot, and stores are accepted again after that.
- R10: A 1 in `irq_clr` clears that status bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: `irq_out` is the OR of the status bits that are enabled in `irq_en`. Masking a bit does not alter the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_last | input | IDX_W | Transmit descriptor count minus one |
| cfg_rx_last | input | IDX_W | Receive descriptor count minus one |
| sw_tx_prod_wr | input | 1 | Software write strobe for the transmit produce index |
| sw_tx_prod_val | input | IDX_W | New transmit produce index |
| eng_tx_done | input | 1 | Engine finished the frame at `tx_consume` |
| eng_tx_irq_req | input | 1 | Interrupt flag of the finished transmit descriptor |
| tx_produce | output | IDX_W | Transmit produce index |
| tx_consume | output | IDX_W | Transmit consume index |
| tx_empty | output | 1 | Transmit ring empty |
| tx_full | output | 1 | Transmit ring full |
| eng_rx_store | input | 1 | Engine offers a received frame |
| eng_rx_irq_req | input | 1 | Interrupt flag of the receive descriptor |
| eng_rx_len | input | LEN_W | Received byte count (at least 1) |
| sw_rx_cons_wr | input | 1 | Software write strobe for the receive consume index |
| sw_rx_cons_val | input | IDX_W | New receive consume index |
| rx_produce | output | IDX_W | Receive produce index |
| rx_consume | output | IDX_W | Receive consume index |
| rx_empty | output | 1 | Receive ring empty |
| rx_full | output | 1 | Next receive store would collide with the consume index |
| rx_overrun | output | 1 | Receive side stalled after a dropped frame |
| rx_stat_idx | input | IDX_W | Slot whose length word is read |
| rx_stat_size | output | LEN_W | Stored byte count minus one for that slot |
| irq_en | input | 2 | Interrupt enable mask (bit 0 transmit-done, bit 1 receive-done) |
| irq_clr | input | 2 | Write-one-to-clear strobes, same bit order |
| irq_status | output | 2 | Raw interrupt status, same bit order |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The assertions check on every cycle the following relations: empty against index equality, the full/empty exclusion, wrap at the programmed last value, that a done pulse on an empty ring does not move the index, that interrupt bits rise after flagged acceptances, that a clear takes effect, masking of `irq_out`, and that the receive produce index is frozen while stalled. Only the bench scenarios can show the other behaviours. These are the stored length words per slot, the full sequence of filling the transmit ring to count minus one, leaving the stall once software frees a slot, and set-over-clear priority on the receive bit.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam int IRQ_N  = 2;
    localparam int IRQ_TX = 0;
    localparam int IRQ_RX = 1;

    typedef enum logic {
        TX_IDLE,
        TX_PENDING
    } tx_state_e;

    typedef enum logic {
        RX_RUN,
        RX_STALL
    } rx_state_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] last,
    input  logic             adv,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] succ;

    always_comb begin
        succ = (idx_q == last) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= load_val;
        end else if (adv) begin
            idx_q <= succ;
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/rx_len_store.sv
module rx_len_store #(
    parameter int IDX_W = 4,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LEN_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LEN_W-1:0] rd_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LEN_W-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [LEN_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                word_q <= wr_val;
            end
        end
        assign slot_q[s] = word_q;
    end

    assign rd_val = slot_q[rd_idx];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] set,
    input  logic [IRQ_N-1:0] clr,
    input  logic [IRQ_N-1:0] en,
    output logic [IRQ_N-1:0] status,
    output logic             irq
);
    logic [IRQ_N-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | set;
        end
    end

    assign status = status_q;
    assign irq    = |(status_q & en);
endmodule

// File: rtl/ring_index_mgr.sv
module ring_index_mgr
    import ring_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cfg_tx_last,
    input  logic [IDX_W-1:0] cfg_rx_last,
    input  logic             sw_tx_prod_wr,
    input  logic [IDX_W-1:0] sw_tx_prod_val,
    input  logic             eng_tx_done,
    input  logic             eng_tx_irq_req,
    output logic [IDX_W-1:0] tx_produce,
    output logic [IDX_W-1:0] tx_consume,
    output logic             tx_empty,
    output logic             tx_full,
    input  logic             eng_rx_store,
    input  logic             eng_rx_irq_req,
    input  logic [LEN_W-1:0] eng_rx_len,
    input  logic             sw_rx_cons_wr,
    input  logic [IDX_W-1:0] sw_rx_cons_val,
    output logic [IDX_W-1:0] rx_produce,
    output logic [IDX_W-1:0] rx_consume,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_overrun,
    input  logic [IDX_W-1:0] rx_stat_idx,
    output logic [LEN_W-1:0] rx_stat_size,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       irq_clr,
    output logic [1:0]       irq_status,
    output logic             irq_out
);
    function automatic logic [IDX_W-1:0] wrap_inc(logic [IDX_W-1:0] v, logic [IDX_W-1:0] lim);
        return (v == lim) ? '0 : v + 1'b1;
    endfunction

    tx_state_e tx_state_q, tx_state_d;
    rx_state_e rx_state_q, rx_state_d;

    logic             tx_accept;
    logic             rx_accept;
    logic [IDX_W-1:0] tx_prod_d;
    logic [IDX_W-1:0] tx_cons_d;
    logic [IRQ_N-1:0] irq_set;

    // transmit index pair
    ring_ptr #(.IDX_W(IDX_W)) u_tx_prod (
        .clk(clk), .rst_n(rst_n), .last(cfg_tx_last),
        .adv(1'b0), .load(sw_tx_prod_wr), .load_val(sw_tx_prod_val),
        .idx(tx_produce)
    );
    ring_ptr #(.IDX_W(IDX_W)) u_tx_cons (
        .clk(clk), .rst_n(rst_n), .last(cfg_tx_last),
        .adv(tx_accept), .load(1'b0), .load_val('0),
        .idx(tx_consume)
    );

    // receive index pair
    ring_ptr #(.IDX_W(IDX_W)) u_rx_prod (
        .clk(clk), .rst_n(rst_n), .last(cfg_rx_last),
        .adv(rx_accept), .load(1'b0), .load_val('0),
        .idx(rx_produce)
    );
    ring_ptr #(.IDX_W(IDX_W)) u_rx_cons (
        .clk(clk), .rst_n(rst_n), .last(cfg_rx_last),
        .adv(1'b0), .load(sw_rx_cons_wr), .load_val(sw_rx_cons_val),
        .idx(rx_consume)
    );

    rx_len_store #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_accept), .wr_idx(rx_produce), .wr_val(eng_rx_len - 1'b1),
        .rd_idx(rx_stat_idx), .rd_val(rx_stat_size)
    );

    irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .set(irq_set), .clr(irq_clr), .en(irq_en),
        .status(irq_status), .irq(irq_out)
    );

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_state_q <= TX_IDLE;
            rx_state_q <= RX_RUN;
        end else begin
            tx_state_q <= tx_state_d;
            rx_state_q <= rx_state_d;
        end
    end

    // next-state logic, looking at next-cycle indices on the transmit side
    always_comb begin
        tx_prod_d  = sw_tx_prod_wr ? sw_tx_prod_val : tx_produce;
        tx_cons_d  = tx_accept ? wrap_inc(tx_consume, cfg_tx_last) : tx_consume;
        tx_state_d = tx_state_q;
        unique case (tx_state_q)
            TX_IDLE:    if (tx_prod_d != tx_cons_d) tx_state_d = TX_PENDING;
            TX_PENDING: if (tx_prod_d == tx_cons_d) tx_state_d = TX_IDLE;
            default:    tx_state_d = TX_IDLE;
        endcase

        rx_state_d = rx_state_q;
        unique case (rx_state_q)
            RX_RUN:   if (eng_rx_store && rx_full) rx_state_d = RX_STALL;
            RX_STALL: if (!rx_full) rx_state_d = RX_RUN;
            default:  rx_state_d = RX_RUN;
        endcase
    end

    // outputs derived from state and indices
    always_comb begin
        tx_empty   = (tx_state_q == TX_IDLE);
        tx_full    = (wrap_inc(tx_produce, cfg_tx_last) == tx_consume);
        tx_accept  = eng_tx_done && (tx_state_q == TX_PENDING);

        rx_empty   = (rx_produce == rx_consume);
        rx_full    = (wrap_inc(rx_produce, cfg_rx_last) == rx_consume);
        rx_overrun = (rx_state_q == RX_STALL);
        rx_accept  = eng_rx_store && (rx_state_q == RX_RUN) && !rx_full;

        irq_set         = '0;
        irq_set[IRQ_TX] = tx_accept && eng_tx_irq_req;
        irq_set[IRQ_RX] = rx_accept && eng_rx_irq_req;
    end
endmodule

// File: rtl/ring_index_mgr_chk.sv
module ring_index_mgr_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] cfg_tx_last,
    input logic             eng_tx_done,
    input logic             eng_tx_irq_req,
    input logic [IDX_W-1:0] tx_produce,
    input logic [IDX_W-1:0] tx_consume,
    input logic             tx_empty,
    input logic             tx_full,
    input logic             eng_rx_store,
    input logic             eng_rx_irq_req,
    input logic [IDX_W-1:0] rx_produce,
    input logic             rx_full,
    input logic             rx_overrun,
    input logic [1:0]       irq_en,
    input logic [1:0]       irq_clr,
    input logic [1:0]       irq_status,
    input logic             irq_out
);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_done && !tx_empty && tx_consume == cfg_tx_last) |=> (tx_consume == '0));

    assert_empty_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty == (tx_produce == tx_consume));

    assert_full_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_last != '0 && tx_full) |-> !tx_empty);

    assert_done_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_done && tx_empty) |=> $stable(tx_consume));

    assert_txdone_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_done && !tx_empty && eng_tx_irq_req) |=> irq_status[0]);

    assert_rxdone_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_store && !rx_full && !rx_overrun && eng_rx_irq_req) |=> irq_status[1]);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_store && (rx_full || rx_overrun)) |=> $stable(rx_produce));

    assert_stall_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_store && rx_full) |=> rx_overrun);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr[0] && !(eng_tx_done && !tx_empty && eng_tx_irq_req)) |=> !irq_status[0]);

    assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq_out);
endmodule

bind ring_index_mgr ring_index_mgr_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_tx_last(cfg_tx_last),
    .eng_tx_done(eng_tx_done), .eng_tx_irq_req(eng_tx_irq_req),
    .tx_produce(tx_produce), .tx_consume(tx_consume),
    .tx_empty(tx_empty), .tx_full(tx_full),
    .eng_rx_store(eng_rx_store), .eng_rx_irq_req(eng_rx_irq_req),
    .rx_produce(rx_produce), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status), .irq_out(irq_out)
);

// File: tb/ring_index_mgr_bench.sv
module ring_index_mgr_bench;
    localparam int IDX_W = 4;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] cfg_tx_last = 4'd3;
    logic [IDX_W-1:0] cfg_rx_last = 4'd3;
    logic             sw_tx_prod_wr = 1'b0;
    logic [IDX_W-1:0] sw_tx_prod_val = '0;
    logic             eng_tx_done = 1'b0;
    logic             eng_tx_irq_req = 1'b0;
    logic [IDX_W-1:0] tx_produce, tx_consume;
    logic             tx_empty, tx_full;
    logic             eng_rx_store = 1'b0;
    logic             eng_rx_irq_req = 1'b0;
    logic [LEN_W-1:0] eng_rx_len = '0;
    logic             sw_rx_cons_wr = 1'b0;
    logic [IDX_W-1:0] sw_rx_cons_val = '0;
    logic [IDX_W-1:0] rx_produce, rx_consume;
    logic             rx_empty, rx_full, rx_overrun;
    logic [IDX_W-1:0] rx_stat_idx = '0;
    logic [LEN_W-1:0] rx_stat_size;
    logic [1:0]       irq_en = 2'b00;
    logic [1:0]       irq_clr = 2'b00;
    logic [1:0]       irq_status;
    logic             irq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ring_index_mgr #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ring_index_mgr (.*);

    typedef struct {
        int          sel;
        string       req;
        logic [31:0] exp;
    } item_t;
    item_t exp_q[$];

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0:  return 32'(tx_produce);
            1:  return 32'(tx_consume);
            2:  return 32'(tx_empty);
            3:  return 32'(tx_full);
            4:  return 32'(rx_produce);
            5:  return 32'(rx_consume);
            6:  return 32'(rx_empty);
            7:  return 32'(rx_full);
            8:  return 32'(rx_overrun);
            9:  return 32'(irq_status);
            10: return 32'(irq_out);
            default: return 32'(rx_stat_size);
        endcase
    endfunction

    // monitor: pops expected items and compares against the outputs
    always @(negedge clk) begin
        item_t it;
        while (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            n_checks++;
            if (observe(it.sel) !== it.exp) begin
                n_errors++;
                $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, observe(it.sel), it.exp);
            end
        end
    end

    task automatic push(int sel, string req, logic [31:0] exp);
        item_t it;
        it.sel = sel; it.req = req; it.exp = exp;
        exp_q.push_back(it);
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic tx_write(logic [IDX_W-1:0] v);
        cyc(); sw_tx_prod_wr = 1'b1; sw_tx_prod_val = v;
        cyc(); sw_tx_prod_wr = 1'b0;
    endtask

    task automatic tx_done(logic flag);
        cyc(); eng_tx_done = 1'b1; eng_tx_irq_req = flag;
        cyc(); eng_tx_done = 1'b0; eng_tx_irq_req = 1'b0;
    endtask

    task automatic rx_store(logic [LEN_W-1:0] len, logic flag, logic [1:0] clr);
        cyc(); eng_rx_store = 1'b1; eng_rx_len = len; eng_rx_irq_req = flag; irq_clr = clr;
        cyc(); eng_rx_store = 1'b0; eng_rx_irq_req = 1'b0; irq_clr = 2'b00;
    endtask

    task automatic rx_release(logic [IDX_W-1:0] v);
        cyc(); sw_rx_cons_wr = 1'b1; sw_rx_cons_val = v;
        cyc(); sw_rx_cons_wr = 1'b0;
    endtask

    task automatic clear_irq(logic [1:0] m);
        cyc(); irq_clr = m;
        cyc(); irq_clr = 2'b00;
    endtask

    task automatic read_len(logic [IDX_W-1:0] s, logic [31:0] exp);
        rx_stat_idx = s;
        #1;
        push(11, "R8", exp);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        push(0, "R1", 0); push(1, "R1", 0); push(2, "R1", 1); push(3, "R1", 0);
        push(6, "R1", 1); push(7, "R1", 0); push(9, "R1", 0); push(10, "R1", 0);
        push(8, "R1", 0);
        settle();

        // R3 non-empty after software publishes one descriptor
        tx_write(4'd1);
        push(0, "R3", 1); push(2, "R3", 0);
        settle();

        // R6 flagged transmit completion; R11 masked then enabled
        tx_done(1'b1);
        push(1, "R6", 1); push(2, "R3", 1); push(9, "R6", 2'b01); push(10, "R11", 0);
        settle();
        cyc(); irq_en = 2'b01;
        settle();
        push(10, "R11", 1); push(9, "R11", 2'b01);
        settle();

        // R10 write-one-to-clear
        clear_irq(2'b01);
        push(9, "R10", 0); push(10, "R10", 0);
        settle();

        // R5 done while empty is ignored
        tx_done(1'b1);
        push(1, "R5", 1); push(9, "R5", 0);
        settle();

        // R4 fill to count minus one
        tx_write(4'd0);
        push(3, "R4", 1); push(2, "R4", 0);
        settle();

        // R2 wrap of the transmit consume index, R6 no flag means no bit
        tx_done(1'b0); tx_done(1'b0);
        push(1, "R2", 3);
        settle();
        tx_done(1'b0);
        push(1, "R2", 0); push(2, "R3", 1); push(3, "R4", 0); push(9, "R6", 0);
        settle();

        // R7 receive-done with flag, R8 length minus one
        cyc(); irq_en = 2'b10;
        rx_store(11'd64, 1'b1, 2'b00);
        push(4, "R7", 1); push(9, "R7", 2'b10); push(10, "R11", 1);
        settle();
        read_len(4'd0, 63);
        clear_irq(2'b10);

        rx_store(11'd1, 1'b0, 2'b00);
        push(4, "R7", 2); push(9, "R7", 0);
        settle();
        read_len(4'd1, 0);

        rx_store(11'd1500, 1'b1, 2'b00);
        push(4, "R8", 3); push(7, "R9", 1); push(8, "R9", 0);
        settle();
        read_len(4'd2, 1499);
        clear_irq(2'b10);

        // R9 overrun: dropped stores, stall until space
        rx_store(11'd5, 1'b1, 2'b00);
        push(4, "R9", 3); push(8, "R9", 1); push(9, "R9", 0);
        settle();
        rx_store(11'd6, 1'b0, 2'b00);
        push(4, "R9", 3); push(8, "R9", 1);
        settle();
        rx_release(4'd1);
        cyc();
        push(5, "R9", 1); push(7, "R9", 0); push(8, "R9", 0);
        settle();

        // R2 receive produce wrap, R8 on the last slot
        rx_store(11'd10, 1'b0, 2'b00);
        push(4, "R2", 0); push(8, "R9", 0);
        settle();
        read_len(4'd3, 9);

        rx_release(4'd0);
        push(6, "R3", 1);
        settle();

        // R10 set wins over clear in the same cycle
        rx_store(11'd20, 1'b1, 2'b10);
        push(9, "R10", 2'b10); push(4, "R7", 1);
        settle();
        clear_irq(2'b10);
        push(9, "R10", 0);
        settle();

        settle();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule